// File: doc/BRIEF.md
# Two-Stage Timeout Watchdog with APB Register Port

This peripheral guards a system against software that stops responding. A down-counter advances by one on every cycle in which the tick-enable input is high. It reloads from a programmable load value. The first time the count runs out, a raw interrupt flag is raised and counting starts again. If the count runs out a second time before software has cleared that flag, a sticky reset flag is set and the counter halts. Each flag reaches its output pin only when its own enable bit in the control register is set.

Software reaches the block through an APB3 slave port with no wait states. The port offers load, current value, control, interrupt clear, raw and masked status, a write-lock key register, an integration-test mode, and read-only identification bytes. While the block is locked, every register write is dropped except a write to the lock register. In integration-test mode, the two output pins follow a test register instead of the flags.

The counter is controlled by a three-state machine. `ST_RUN` decrements on each tick. An expiry tick (the count goes from 1 to 0) moves to `ST_WRAP` when the interrupt flag was clear, and to `ST_STOP` when it was already set. From `ST_WRAP`, the next tick reloads the count and returns to `ST_RUN`. `ST_STOP` ignores ticks. A load write always returns to `ST_RUN`. An interrupt-clear write returns `ST_WRAP` to `ST_RUN` and leaves `ST_STOP` unchanged. When the count is 0 in `ST_RUN` (a load of zero), a tick reloads the count without an expiry.

Top module: `tick_watchdog`

## Requirements
- R1: After reset, the following read 0: control, raw status, lock (byte offset 0xC00) and test control. The load and the current value (offset 0x004) read 0xFFFFFFFF. Both output pins are low. The counter is running, so ticks decrement it.
- R2: A write to the load register (offset 0x000) stores the value. At the same clock edge it copies the value into the counter and enters `ST_RUN`, which also restarts a halted counter.
- R3: The count changes only on a clock edge where tick-enable is high. Register reads leave it unchanged.
- R4: An expiry tick with the raw flag clear sets the raw flag (offset 0x010, bit 0) and leaves the count at 0. The next tick reloads the count from the load value.
- R5: An expiry tick with the raw flag already set does two things: it sets the sticky reset flag and it halts the counter at 0. Further ticks do not change the count.
- R6: Any write to the interrupt-clear register (offset 0x00C) clears the raw flag and reloads the count. The reset flag stays set. A halted counter stays halted. After a clear, a later expiry raises only the interrupt again.
- R7: The interrupt pin is the raw flag ANDed with control bit 0 (offset 0x008). The reset pin is the reset flag ANDed with control bit 1. The masked status register (offset 0x014) reads the masked interrupt.
- R8: Writing 0x1ACCE551 to the lock register unlocks the block, and writing any other value locks it. The lock register reads 1 when locked. While locked, writes to all other registers are ignored.
- R9: When test-control bit 0 (offset 0xF00) is set, the interrupt pin follows test-output bit 1 (offset 0xF04) and the reset pin follows test-output bit 0.
- R10: Offsets 0xFD0 to 0xFFC read constant bytes, one per word, in this order: 0x04, 0x00, 0x00, 0x00, 0x24, 0xB8, 0x1B, 0x00, 0x0D, 0xF0, 0x05, 0xB1.
- R11: Reads of the interrupt-clear register, the test-output register and unmapped offsets return 0. Writes to read-only or unmapped offsets have no effect. Control stores only bits 1:0 and test control stores only bit 0.
- R12: PREADY is always 1 and PSLVERR is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | Clock |
| presetn | input | 1 | Active-low reset |
| paddr | input | 12 | Byte address |
| psel | input | 1 | Slave select |
| penable | input | 1 | Access phase |
| pwrite | input | 1 | 1 = write |
| pwdata | input | 32 | Write data |
| prdata | output | 32 | Read data |
| pready | output | 1 | Always ready |
| pslverr | output | 1 | Never errors |
| tick_en | input | 1 | Count enable strobe |
| wdog_irq | output | 1 | Interrupt request |
| wdog_rst | output | 1 | Reset request |

## Verification
The timeout path is driven with short loads in three patterns:

- **No clear:** two expiries in a row with no clear in between, so the interrupt is followed by a reset and a halt.
- **Clear between expiries:** a second expiry must raise only the interrupt again.
- **Clear after the halt:** the clear must reload the count without restarting it.

Tick bursts alternate with idle stretches, which separates decrements on ticks from drift without ticks. Reads of the count after the expiry tick and after the tick that follows show that the reload takes an extra tick. The lock, test-mode and masking checks use control and test values that give a different pin result from the flag path.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
    localparam int unsigned DW     = 32;
    localparam int unsigned AW     = 12;

    localparam logic [AW-1:0] OFF_LOAD  = 12'h000;
    localparam logic [AW-1:0] OFF_VALUE = 12'h004;
    localparam logic [AW-1:0] OFF_CTRL  = 12'h008;
    localparam logic [AW-1:0] OFF_CLR   = 12'h00C;
    localparam logic [AW-1:0] OFF_RIS   = 12'h010;
    localparam logic [AW-1:0] OFF_MIS   = 12'h014;
    localparam logic [AW-1:0] OFF_LOCK  = 12'hC00;
    localparam logic [AW-1:0] OFF_TCTL  = 12'hF00;
    localparam logic [AW-1:0] OFF_TOUT  = 12'hF04;
    localparam logic [AW-1:0] OFF_ID_LO = 12'hFD0;
    localparam logic [AW-1:0] OFF_ID_HI = 12'hFFC;

    localparam logic [DW-1:0] UNLOCK_KEY = 32'h1ACC_E551;

    typedef enum logic [1:0] {
        ST_RUN  = 2'd0,
        ST_WRAP = 2'd1,
        ST_STOP = 2'd2
    } cnt_state_e;

    function automatic logic [7:0] id_byte(input logic [3:0] idx);
        case (idx)
            4'd0:    id_byte = 8'h04;
            4'd4:    id_byte = 8'h24;
            4'd5:    id_byte = 8'hB8;
            4'd6:    id_byte = 8'h1B;
            4'd8:    id_byte = 8'h0D;
            4'd9:    id_byte = 8'hF0;
            4'd10:   id_byte = 8'h05;
            4'd11:   id_byte = 8'hB1;
            default: id_byte = 8'h00;
        endcase
    endfunction
endpackage

// File: rtl/wdt_counter.sv
module wdt_counter
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic             load_wr,
    input  logic             clr_wr,
    input  logic [CNT_W-1:0] new_load,
    input  logic [CNT_W-1:0] load_val,
    output logic [CNT_W-1:0] count,
    output logic             irq_raw,
    output logic             rst_flag
);
    localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

    cnt_state_e      st, st_nxt;
    logic [CNT_W-1:0] cnt_nxt;
    logic             irq_nxt, rstf_nxt;

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st <= ST_RUN;
        else        st <= st_nxt;
    end

    // next state and datapath decisions
    always_comb begin
        st_nxt   = st;
        cnt_nxt  = count;
        irq_nxt  = irq_raw;
        rstf_nxt = rst_flag;
        if (load_wr) begin
            cnt_nxt = new_load;
            st_nxt  = ST_RUN;
        end else if (clr_wr) begin
            cnt_nxt = load_val;
            irq_nxt = 1'b0;
            if (st != ST_STOP) st_nxt = ST_RUN;
        end else if (tick) begin
            unique case (st)
                ST_RUN: begin
                    if (count == ONE) begin
                        cnt_nxt = '0;
                        if (irq_raw) begin
                            rstf_nxt = 1'b1;
                            st_nxt   = ST_STOP;
                        end else begin
                            irq_nxt = 1'b1;
                            st_nxt  = ST_WRAP;
                        end
                    end else if (count == '0) begin
                        cnt_nxt = load_val;
                    end else begin
                        cnt_nxt = count - ONE;
                    end
                end
                ST_WRAP: begin
                    cnt_nxt = load_val;
                    st_nxt  = ST_RUN;
                end
                ST_STOP: ;
                default: st_nxt = ST_RUN;
            endcase
        end
    end

    // registered outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            count    <= '1;
            irq_raw  <= 1'b0;
            rst_flag <= 1'b0;
        end else begin
            count    <= cnt_nxt;
            irq_raw  <= irq_nxt;
            rst_flag <= rstf_nxt;
        end
    end

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && !load_wr && !clr_wr) |=> $stable(count)); // R3
    AST_STOP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_STOP && !load_wr && !clr_wr) |=> $stable(count)); // R5
    AST_RST_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        rst_flag |=> rst_flag); // R6
    AST_RST_AFTER_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_flag) |-> $past(irq_raw)); // R5
    AST_LOAD_TAKES: assert property (@(posedge clk) disable iff (!rst_n)
        load_wr |=> (count == $past(new_load))); // R2
endmodule

// File: rtl/wdt_regs.sv
module wdt_regs
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [AW-1:0]    paddr,
    input  logic             psel,
    input  logic             penable,
    input  logic             pwrite,
    input  logic [DW-1:0]    pwdata,
    output logic [DW-1:0]    prdata,
    input  logic [CNT_W-1:0] count,
    input  logic             irq_raw,
    output logic             load_wr,
    output logic             clr_wr,
    output logic [CNT_W-1:0] new_load,
    output logic [CNT_W-1:0] load_q,
    output logic [1:0]       ctrl_q,
    output logic             tctl_q,
    output logic [1:0]       tout_q
);
    logic wr_any, wr_ok, locked;
    logic [AW-1:0] id_off;

    assign wr_any   = psel & penable & pwrite;
    assign wr_ok    = wr_any & ~locked;
    assign load_wr  = wr_ok & (paddr == OFF_LOAD);
    assign clr_wr   = wr_ok & (paddr == OFF_CLR);
    assign new_load = CNT_W'(pwdata);
    assign id_off   = paddr - OFF_ID_LO;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            load_q <= '1;
            ctrl_q <= '0;
            tctl_q <= 1'b0;
            tout_q <= '0;
            locked <= 1'b0;
        end else begin
            if (wr_any && paddr == OFF_LOCK) locked <= (pwdata != UNLOCK_KEY);
            if (load_wr)                      load_q <= new_load;
            if (wr_ok && paddr == OFF_CTRL)   ctrl_q <= pwdata[1:0];
            if (wr_ok && paddr == OFF_TCTL)   tctl_q <= pwdata[0];
            if (wr_ok && paddr == OFF_TOUT)   tout_q <= pwdata[1:0];
        end
    end

    always_comb begin
        prdata = '0;
        unique case (paddr)
            OFF_LOAD:  prdata = DW'(load_q);
            OFF_VALUE: prdata = DW'(count);
            OFF_CTRL:  prdata = DW'(ctrl_q);
            OFF_RIS:   prdata = DW'(irq_raw);
            OFF_MIS:   prdata = DW'(irq_raw & ctrl_q[0]);
            OFF_LOCK:  prdata = DW'(locked);
            OFF_TCTL:  prdata = DW'(tctl_q);
            default: begin
                if (paddr >= OFF_ID_LO && paddr <= OFF_ID_HI && id_off[1:0] == 2'b00)
                    prdata = DW'(id_byte(id_off[5:2]));
            end
        endcase
    end

    AST_LOCKED_CTRL: assert property (@(posedge clk) disable iff (!rst_n)
        (locked && wr_any && paddr != OFF_LOCK) |=> $stable(ctrl_q)); // R8
    AST_KEY_OPENS: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_any && paddr == OFF_LOCK && pwdata == UNLOCK_KEY) |=> !locked); // R8
endmodule

// File: rtl/tick_watchdog.sv
module tick_watchdog
    import wdt_pkg::*;
#(
    parameter int unsigned CNT_W = 32
) (
    input  logic          pclk,
    input  logic          presetn,
    input  logic [AW-1:0] paddr,
    input  logic          psel,
    input  logic          penable,
    input  logic          pwrite,
    input  logic [DW-1:0] pwdata,
    output logic [DW-1:0] prdata,
    output logic          pready,
    output logic          pslverr,
    input  logic          tick_en,
    output logic          wdog_irq,
    output logic          wdog_rst
);
    logic             load_wr, clr_wr, irq_raw, rst_flag, tctl_q;
    logic [CNT_W-1:0] new_load, load_q, count;
    logic [1:0]       ctrl_q, tout_q;

    assign pready  = 1'b1;
    assign pslverr = 1'b0;

    wdt_regs #(.CNT_W(CNT_W)) u_regs (
        .clk(pclk), .rst_n(presetn), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .count(count), .irq_raw(irq_raw), .load_wr(load_wr), .clr_wr(clr_wr),
        .new_load(new_load), .load_q(load_q), .ctrl_q(ctrl_q),
        .tctl_q(tctl_q), .tout_q(tout_q)
    );

    wdt_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk(pclk), .rst_n(presetn), .tick(tick_en), .load_wr(load_wr),
        .clr_wr(clr_wr), .new_load(new_load), .load_val(load_q),
        .count(count), .irq_raw(irq_raw), .rst_flag(rst_flag)
    );

    always_comb begin
        if (tctl_q) begin
            wdog_irq = tout_q[1];
            wdog_rst = tout_q[0];
        end else begin
            wdog_irq = irq_raw & ctrl_q[0];
            wdog_rst = rst_flag & ctrl_q[1];
        end
    end

    AST_RST_PIN_GATED: assert property (@(posedge pclk) disable iff (!presetn)
        (!tctl_q && !ctrl_q[1]) |-> !wdog_rst); // R7
endmodule

// File: tb/tick_watchdog_test.sv
module tick_watchdog_test;
    localparam time PERIOD = 10ns;

    logic        pclk = 1'b0;
    logic        presetn = 1'b0;
    logic [11:0] paddr = '0;
    logic        psel = 1'b0, penable = 1'b0, pwrite = 1'b0;
    logic [31:0] pwdata = '0;
    logic [31:0] prdata;
    logic        pready, pslverr, tick_en = 1'b0, wdog_irq, wdog_rst;

    int n_cmp = 0;
    int n_bad = 0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } exp_t;
    exp_t sb_q[$];
    event rd_ev;

    tick_watchdog uut (
        .pclk(pclk), .presetn(presetn), .paddr(paddr), .psel(psel),
        .penable(penable), .pwrite(pwrite), .pwdata(pwdata), .prdata(prdata),
        .pready(pready), .pslverr(pslverr), .tick_en(tick_en),
        .wdog_irq(wdog_irq), .wdog_rst(wdog_rst)
    );

    always #(PERIOD/2) pclk = ~pclk;

    // monitor: pops expected read data and compares
    initial begin
        forever begin
            @(rd_ev);
            if (sb_q.size() != 0) begin
                exp_t it;
                it = sb_q.pop_front();
                n_cmp++;
                if (prdata !== it.exp) begin
                    n_bad++;
                    $display("FAIL %s: read got %h expected %h", it.tag, prdata, it.exp);
                end
            end
        end
    end

    task automatic apb_write(input logic [11:0] a, input logic [31:0] d);
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b1; paddr = a; pwdata = d;
        @(negedge pclk);
        penable = 1'b1;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0; pwrite = 1'b0;
    endtask

    task automatic apb_read(input logic [11:0] a, input logic [31:0] e, input string tag);
        exp_t it;
        @(negedge pclk);
        psel = 1'b1; penable = 1'b0; pwrite = 1'b0; paddr = a;
        @(negedge pclk);
        penable = 1'b1;
        it.exp = e; it.tag = tag;
        sb_q.push_back(it);
        #(PERIOD/4);
        -> rd_ev;
        @(negedge pclk);
        psel = 1'b0; penable = 1'b0;
    endtask

    task automatic pin(input logic act, input logic e, input string tag);
        n_cmp++;
        if (act !== e) begin
            n_bad++;
            $display("FAIL %s: pin got %b expected %b", tag, act, e);
        end
    endtask

    task automatic ticks(input int n);
        @(negedge pclk);
        tick_en = 1'b1;
        repeat (n) @(negedge pclk);
        tick_en = 1'b0;
    endtask

    task automatic do_reset();
        @(negedge pclk);
        presetn = 1'b0; tick_en = 1'b0;
        repeat (3) @(negedge pclk);
        presetn = 1'b1;
    endtask

    initial begin
        #(PERIOD * 20000);
        n_bad++;
        $display("FAIL watchdog: run hung, got timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        do_reset();
        // R1 reset state
        apb_read(12'h008, 32'h0, "R1 ctrl");
        apb_read(12'h010, 32'h0, "R1 ris");
        apb_read(12'hC00, 32'h0, "R1 lock");
        apb_read(12'hF00, 32'h0, "R1 tctl");
        apb_read(12'h000, 32'hFFFF_FFFF, "R1 load");
        apb_read(12'h004, 32'hFFFF_FFFF, "R1 value");
        pin(wdog_irq, 1'b0, "R1 irq");
        pin(wdog_rst, 1'b0, "R1 rst");
        ticks(2);
        apb_read(12'h004, 32'hFFFF_FFFD, "R1 running");
        pin(pready, 1'b1, "R12 pready");
        pin(pslverr, 1'b0, "R12 pslverr");

        // R2 / R3 load and gated decrement
        apb_write(12'h000, 32'd5);
        apb_read(12'h004, 32'd5, "R2 load copies");
        ticks(2);
        apb_read(12'h004, 32'd3, "R3 two ticks");
        repeat (5) @(negedge pclk);
        apb_read(12'h004, 32'd3, "R3 idle hold");

        // R4 first expiry
        ticks(3);
        apb_read(12'h010, 32'h1, "R4 ris set");
        apb_read(12'h004, 32'h0, "R4 count zero");
        pin(wdog_irq, 1'b0, "R7 irq masked");
        apb_read(12'h014, 32'h0, "R7 mis masked");
        ticks(1);
        apb_read(12'h004, 32'd5, "R4 reload next tick");

        // R7 enable outputs
        apb_write(12'h008, 32'h3);
        pin(wdog_irq, 1'b1, "R7 irq on");
        apb_read(12'h014, 32'h1, "R7 mis on");
        pin(wdog_rst, 1'b0, "R5 no rst yet");

        // R5 second expiry
        ticks(4);
        pin(wdog_rst, 1'b0, "R5 before expiry");
        ticks(1);
        pin(wdog_rst, 1'b1, "R5 rst raised");
        apb_read(12'h004, 32'h0, "R5 halted at 0");
        ticks(3);
        apb_read(12'h004, 32'h0, "R5 stays halted");

        // R6 clear after halt
        apb_write(12'h00C, 32'h0);
        apb_read(12'h010, 32'h0, "R6 ris cleared");
        pin(wdog_irq, 1'b0, "R6 irq low");
        pin(wdog_rst, 1'b1, "R6 rst sticky");
        apb_read(12'h004, 32'd5, "R6 reload");
        ticks(3);
        apb_read(12'h004, 32'd5, "R6 still halted");
        apb_write(12'h000, 32'd2);
        ticks(1);
        apb_read(12'h004, 32'd1, "R2 load restarts");

        // R6 clear between expiries
        do_reset();
        apb_write(12'h000, 32'd2);
        apb_write(12'h008, 32'h1);
        ticks(2);
        apb_read(12'h010, 32'h1, "R6 first expiry");
        pin(wdog_irq, 1'b1, "R7 irq only bit0");
        apb_write(12'h00C, 32'hDEAD);
        apb_read(12'h004, 32'd2, "R6 clear reload");
        ticks(2);
        apb_read(12'h010, 32'h1, "R6 irq again");
        apb_write(12'h008, 32'h3);
        pin(wdog_rst, 1'b0, "R6 no reset after clear");

        // R8 lock
        apb_write(12'hC00, 32'h1234);
        apb_read(12'hC00, 32'h1, "R8 locked");
        apb_write(12'h008, 32'h0);
        apb_read(12'h008, 32'h3, "R8 ctrl kept");
        apb_write(12'h000, 32'd9);
        apb_read(12'h004, 32'h0, "R8 load ignored");
        apb_write(12'h00C, 32'h0);
        apb_read(12'h010, 32'h1, "R8 clear ignored");
        apb_write(12'hC00, 32'h1ACC_E551);
        apb_read(12'hC00, 32'h0, "R8 unlocked");
        apb_write(12'h008, 32'h1);
        apb_read(12'h008, 32'h1, "R8 ctrl writes");

        // R9 / R11 test mode
        apb_write(12'hF00, 32'hFFFF_FFFF);
        apb_read(12'hF00, 32'h1, "R11 tctl bit0 only");
        apb_write(12'hF04, 32'h2);
        pin(wdog_irq, 1'b1, "R9 irq from test");
        pin(wdog_rst, 1'b0, "R9 rst from test");
        apb_write(12'hF04, 32'h1);
        pin(wdog_irq, 1'b0, "R9 irq test low");
        pin(wdog_rst, 1'b1, "R9 rst test high");
        apb_read(12'hF04, 32'h0, "R11 tout reads 0");
        apb_write(12'hF00, 32'h0);
        pin(wdog_irq, 1'b1, "R9 normal irq back");
        pin(wdog_rst, 1'b0, "R9 normal rst back");

        // R11 misc
        apb_write(12'h008, 32'hFFFF_FFFF);
        apb_read(12'h008, 32'h3, "R11 ctrl bits");
        apb_read(12'h00C, 32'h0, "R11 clr reads 0");
        apb_read(12'h100, 32'h0, "R11 unmapped");
        apb_write(12'h004, 32'h1234);
        apb_read(12'h004, 32'h0, "R11 value ro");
        apb_write(12'h010, 32'h0);
        apb_read(12'h010, 32'h1, "R11 ris ro");

        // R10 identification
        for (int i = 0; i < 12; i++) begin
            logic [7:0] e;
            case (i)
                0: e = 8'h04; 4: e = 8'h24; 5: e = 8'hB8; 6: e = 8'h1B;
                8: e = 8'h0D; 9: e = 8'hF0; 10: e = 8'h05; 11: e = 8'hB1;
                default: e = 8'h00;
            endcase
            apb_read(12'hFD0 + 12'(i*4), {24'h0, e}, "R10 id byte");
        end

        repeat (2) @(negedge pclk);
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule